// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block accepts stereo PCM audio on a three-wire serial link made up of a bit clock, a word clock that runs at the sample rate, and a data line. It turns each sample period into a pair of parallel 20-bit words, one left and one right, and hands that pair to the system clock domain with a one-cycle valid strobe. Two static mode inputs choose the framing and the word length. The framings are a right-justified format with 16-bit or 20-bit words, and a 16-bit I2S format.

The receiver samples the data line and the word clock on the rising bit-clock edge. In the right-justified format the word is the most recent bits before a word-clock transition. In I2S the word is the 16 bits that begin one bit clock after a transition. A 16-bit word is sign-extended to 20 bits. A toggle crosses into the system domain through a two-flop synchronizer, and the toggle's edge loads the output registers.

Top module: `serial_audio_rx`

## Requirements
- R1: Data and word clock are both sampled on the rising edge of `sck_i`. Words arrive most significant bit first.
- R2: With `fmt_i2s_i`=0, the word for a half-frame is the N bits sampled last before the word clock changes level. N is 20 when `len20_i`=1 and 16 when `len20_i`=0. Earlier bits in the half-frame have no effect on the output.
- R3: With `fmt_i2s_i`=0, a half-frame with the word clock high carries the left word and a half-frame with the word clock low carries the right word.
- R4: With `fmt_i2s_i`=1, the word clock low marks the left channel. The MSB is the bit sampled on the first rising edge after the word-clock transition. Exactly 16 bits are taken, bits after the 16th are ignored, and `len20_i` has no effect.
- R5: Each 16-bit word is presented with bit 15 copied into bits 19:16. A 20-bit word is presented unchanged.
- R6: Each completed left-then-right pair raises `valid_o` for exactly one `clk_i` cycle, with `left_o`/`right_o` holding that pair. The outputs do not change while `valid_o` is low.
- R7: While `rst_ni` is low, `valid_o`, `left_o` and `right_o` are zero. The half-frame in progress when the first word-clock transition is seen yields no word. No pair is reported until a full left word and then a full right word have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Word clock, one period per stereo sample |
| sd_i | input | 1 | Serial data, MSB first |
| fmt_i2s_i | input | 1 | 1: I2S framing, 0: right-justified |
| len20_i | input | 1 | Right-justified word length, 1: 20 bits, 0: 16 bits |
| left_o | output | 20 | Left sample, sign-extended |
| right_o | output | 20 | Right sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe per new stereo pair |

## Verification
The hardest case to reach is a half-frame that is longer than the word in both framings. In the right-justified format the extra bits come before the word, and in I2S they come after it, so a capture that is off by one position still looks right when the half-frame is exactly full. The stimulus therefore runs each framing both with exactly filled half-frames and with 24-clock half-frames whose spare bit times carry random data. It also starts every run with a partial half-frame that must produce no word, and it includes words with the sign bit set and cleared, all ones and all zeros.

// File: rtl/serial_audio_rx_pkg.sv
`timescale 1ns/1ps
package serial_audio_rx_pkg;
  localparam int unsigned MAX_W   = 20;
  localparam int unsigned SHORT_W = 16;

  typedef logic [MAX_W-1:0] sample_t;

  function automatic sample_t sext_short(logic [SHORT_W-1:0] v);
    return {{(MAX_W-SHORT_W){v[SHORT_W-1]}}, v};
  endfunction
endpackage

// File: rtl/srx_capture.sv
`timescale 1ns/1ps
module srx_capture
  import serial_audio_rx_pkg::*;
(
  input  logic    sck_i,
  input  logic    rst_ni,
  input  logic    ws_i,
  input  logic    sd_i,
  input  logic    fmt_i2s_i,
  input  logic    len20_i,
  output sample_t word_o,
  output logic    word_vld_o,
  output logic    word_left_o
);
  localparam int unsigned CW = $clog2(SHORT_W + 1);

  logic [MAX_W-1:0] sh_q;
  logic             ws_q, ws_seen_q, synced_q, chan_left_q;
  logic [CW-1:0]    cnt_q;
  logic             boundary, i2s_take, i2s_done;

  assign boundary = ws_seen_q && (ws_i != ws_q);
  assign i2s_take = fmt_i2s_i && (cnt_q < CW'(SHORT_W));
  assign i2s_done = i2s_take && (cnt_q == CW'(SHORT_W - 1));

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      ws_q        <= 1'b0;
      ws_seen_q   <= 1'b0;
      synced_q    <= 1'b0;
      chan_left_q <= 1'b0;
      cnt_q       <= CW'(SHORT_W);
    end else begin
      sh_q      <= {sh_q[MAX_W-2:0], sd_i};
      ws_q      <= ws_i;
      ws_seen_q <= 1'b1;
      synced_q  <= synced_q | boundary;
      if (boundary) chan_left_q <= ~ws_i;
      if (fmt_i2s_i && boundary) cnt_q <= '0;
      else if (i2s_take)         cnt_q <= cnt_q + 1'b1;
    end
  end

  // I2S: last bit of the word may coincide with the next word-clock edge
  always_comb begin
    if (fmt_i2s_i) begin
      word_o      = sext_short({sh_q[SHORT_W-2:0], sd_i});
      word_vld_o  = i2s_done;
      word_left_o = chan_left_q;
    end else begin
      word_o      = len20_i ? sh_q : sext_short(sh_q[SHORT_W-1:0]);
      word_vld_o  = boundary && synced_q;
      word_left_o = ws_q;
    end
  end

  AST_I2S_CNT_BOUND: assert property (@(posedge sck_i) disable iff (!rst_ni)
    cnt_q <= CW'(SHORT_W)) else $error("cnt overrun"); // R4
endmodule

// File: rtl/srx_pair.sv
`timescale 1ns/1ps
module srx_pair
  import serial_audio_rx_pkg::*;
(
  input  logic    sck_i,
  input  logic    rst_ni,
  input  sample_t word_i,
  input  logic    word_vld_i,
  input  logic    word_left_i,
  output sample_t pair_l_o,
  output sample_t pair_r_o,
  output logic    tgl_o
);
  sample_t left_hold_q;
  logic    have_left_q;

  always_ff @(posedge sck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      have_left_q <= 1'b0;
      pair_l_o    <= '0;
      pair_r_o    <= '0;
      tgl_o       <= 1'b0;
    end else if (word_vld_i) begin
      if (word_left_i) begin
        left_hold_q <= word_i;
        have_left_q <= 1'b1;
      end else begin
        have_left_q <= 1'b0;
        if (have_left_q) begin
          pair_l_o <= left_hold_q;
          pair_r_o <= word_i;
          tgl_o    <= ~tgl_o;
        end
      end
    end
  end

  AST_PAIR_NEEDS_LEFT: assert property (@(posedge sck_i) disable iff (!rst_ni)
    (tgl_o != $past(tgl_o)) |-> !have_left_q) else $error("pair without left"); // R7
endmodule

// File: rtl/srx_cdc.sv
`timescale 1ns/1ps
module srx_cdc
  import serial_audio_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tgl_i,
  input  sample_t pair_l_i,
  input  sample_t pair_r_i,
  output sample_t left_o,
  output sample_t right_o,
  output logic    valid_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 fire;

  assign fire = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-1:0], tgl_i};
      valid_o <= fire;
      if (fire) begin
        left_o  <= pair_l_i;
        right_o <= pair_r_i;
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o) else $error("valid held"); // R6
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o))) else $error("output moved"); // R6
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx
  import serial_audio_rx_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  ws_i,
  input  logic                  sd_i,
  input  logic                  fmt_i2s_i,
  input  logic                  len20_i,
  output logic [MAX_W-1:0]      left_o,
  output logic [MAX_W-1:0]      right_o,
  output logic                  valid_o
);
  sample_t word, pair_l, pair_r;
  logic    word_vld, word_left, tgl;

  srx_capture u_capture (
    .sck_i, .rst_ni, .ws_i, .sd_i, .fmt_i2s_i, .len20_i,
    .word_o(word), .word_vld_o(word_vld), .word_left_o(word_left)
  );

  srx_pair u_pair (
    .sck_i, .rst_ni,
    .word_i(word), .word_vld_i(word_vld), .word_left_i(word_left),
    .pair_l_o(pair_l), .pair_r_o(pair_r), .tgl_o(tgl)
  );

  srx_cdc #(.SYNC_STAGES(2)) u_cdc (
    .clk_i, .rst_ni, .tgl_i(tgl), .pair_l_i(pair_l), .pair_r_i(pair_r),
    .left_o, .right_o, .valid_o
  );

  AST_SEXT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (fmt_i2s_i || !len20_i)) |->
      ((&left_o[MAX_W-1:SHORT_W-1]) || !(|left_o[MAX_W-1:SHORT_W-1])))
    else $error("left not sign-extended"); // R5
  AST_SEXT_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (fmt_i2s_i || !len20_i)) |->
      ((&right_o[MAX_W-1:SHORT_W-1]) || !(|right_o[MAX_W-1:SHORT_W-1])))
    else $error("right not sign-extended"); // R5
endmodule

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0, fmt = 1'b0, l20 = 1'b0;
  logic [19:0] left, right;
  logic        valid;
  int          checks = 0, errors = 0;

  bit          ws_seq[$];
  bit          sd_seq[$];
  logic [39:0] exp_q[$];
  string       cur_req = "R2";

  always #5 clk = ~clk;

  serial_audio_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .fmt_i2s_i(fmt), .len20_i(l20), .left_o(left), .right_o(right), .valid_o(valid)
  );

  function automatic logic [19:0] sx16(logic [19:0] v);
    return {{4{v[15]}}, v[15:0]};
  endfunction

  function automatic logic [19:0] pick(int f, bit is_left);
    case (f)
      0: return is_left ? 20'h08000 : 20'h07FFF;
      1: return is_left ? 20'hFFFFF : 20'h00000;
      2: return is_left ? 20'h80001 : 20'h7FFFE;
      default: return 20'($urandom);
    endcase
  endfunction

  // per-clock comparison against the reference queue (R6)
  always @(negedge clk) begin
    if (rst_n && valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s R6 unexpected pair L=%h R=%h exp none", cur_req, left, right);
      end else begin
        logic [39:0] e;
        e = exp_q.pop_front();
        if ({left, right} !== e) begin
          errors++;
          $display("FAIL %s L=%h R=%h exp L=%h R=%h", cur_req, left, right, e[39:20], e[19:0]);
        end
      end
    end
  end

  task automatic do_reset(bit i2s, bit len20);
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    fmt = i2s; l20 = len20;
    repeat (4) @(posedge clk);
    #2;
    checks++;
    if (valid !== 1'b0 || left !== '0 || right !== '0) begin
      errors++;
      $display("FAIL R7 reset state v=%b L=%h R=%h exp 0", valid, left, right);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic play();
    while (ws_seq.size() > 0) begin
      sck = 1'b0;
      ws  = ws_seq.pop_front();
      sd  = sd_seq.pop_front();
      #40 sck = 1'b1;   // R1: rising edge samples
      #40;
    end
    sck = 1'b0;
    repeat (20) @(posedge clk);
  endtask

  task automatic end_check(string req);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s missing pairs got %0d exp 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  // right-justified: preamble partial half-frame (R7), garbage lead bits (R2)
  task automatic run_rj(int half, bit len20, int frames);
    int n;
    n = len20 ? 20 : 16;
    for (int i = 0; i < 5; i++) begin ws_seq.push_back(1'b0); sd_seq.push_back(1'($urandom)); end
    for (int f = 0; f < frames; f++) begin
      logic [19:0] lw, rw;
      lw = pick(f, 1'b1); rw = pick(f, 1'b0);
      for (int i = 0; i < half; i++) begin
        ws_seq.push_back(1'b1);   // R3: high = left
        sd_seq.push_back(i >= half - n ? lw[n-1-(i-(half-n))] : 1'($urandom));
      end
      for (int i = 0; i < half; i++) begin
        ws_seq.push_back(1'b0);
        sd_seq.push_back(i >= half - n ? rw[n-1-(i-(half-n))] : 1'($urandom));
      end
      exp_q.push_back(len20 ? {lw, rw} : {sx16(lw), sx16(rw)});
    end
    for (int i = 0; i < 3; i++) begin ws_seq.push_back(1'b1); sd_seq.push_back(1'($urandom)); end
    play();
  endtask

  // I2S: MSB one bit clock after ws change, low = left (R4)
  task automatic run_i2s(int half, int frames);
    int base;
    for (int i = 0; i < 5; i++) begin ws_seq.push_back(1'b1); sd_seq.push_back(1'($urandom)); end
    base = 5;
    for (int f = 0; f < frames; f++) begin
      for (int i = 0; i < 2*half; i++) begin
        ws_seq.push_back(i < half ? 1'b0 : 1'b1);
        sd_seq.push_back(1'($urandom));
      end
    end
    for (int i = 0; i < 4; i++) begin ws_seq.push_back(1'b0); sd_seq.push_back(1'($urandom)); end
    for (int f = 0; f < frames; f++) begin
      logic [19:0] lw, rw;
      int s;
      lw = pick(f, 1'b1); rw = pick(f, 1'b0);
      s = base + f*2*half;
      for (int k = 0; k < 16; k++) begin
        sd_seq[s + 1 + k]        = lw[15-k];
        sd_seq[s + half + 1 + k] = rw[15-k];
      end
      exp_q.push_back({sx16(lw), sx16(rw)});
    end
    play();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R2 R5 16-bit exact";
    do_reset(1'b0, 1'b0); run_rj(16, 1'b0, 5); end_check("R7 R2");
    cur_req = "R2 R5 16-bit padded";
    do_reset(1'b0, 1'b0); run_rj(24, 1'b0, 5); end_check("R2");
    cur_req = "R2 R3 20-bit exact";
    do_reset(1'b0, 1'b1); run_rj(20, 1'b1, 5); end_check("R3");
    cur_req = "R2 R3 20-bit padded";
    do_reset(1'b0, 1'b1); run_rj(24, 1'b1, 5); end_check("R2");
    cur_req = "R4 i2s 32 clocks";
    do_reset(1'b1, 1'b0); run_i2s(16, 5); end_check("R4");
    cur_req = "R4 i2s len20 ignored";
    do_reset(1'b1, 1'b1); run_i2s(16, 4); end_check("R4");
    cur_req = "R4 i2s tail ignored";
    do_reset(1'b1, 1'b0); run_i2s(24, 5); end_check("R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule